// File: doc/BRIEF.md
# Shift-Clock Watchdog with Soft-Start

This block watches a serial shift clock from a free-running reference clock. Any change of the shift-clock level passes through a two-stage synchronizer into the reference domain and counts as activity. When the activity stops for longer than a programmable window, the block forces the LED drive level to zero and raises a sticky watchdog status bit. The serial port reads that bit back.

The block never switches the outputs straight back on, either after reset or after a timeout. When shift-clock activity starts, it ramps a brightness level from 1/8 to 8/8 in eight equal intervals. The output drivers multiply their brightness enable by this level. A control input turns the timeout off completely, for systems that clock the serial chain only now and then.

Top module: `sclk_wdog`

## Requirements
- R1: After reset `lvl_o` is 0, `out_en_o` is 0 and `wd_stat_o` is 0.
- R2: After reset the level stays 0 until the first shift-clock change is seen; time passing alone never starts the ramp.
- R3: A change of `sclk_i` driven just after a reference edge sets the level from 0 to 1 on the third following reference edge.
- R4: With the watchdog enabled, a gap of up to `TIMEOUT_CYC`+3 reference cycles after a shift-clock change leaves the outputs on. A gap of `TIMEOUT_CYC`+4 cycles forces `lvl_o` to 0.
- R5: On timeout `wd_stat_o` is set to 1 in the same cycle that the level drops to 0.
- R6: While `wd_dis_i` is 1, no gap length causes a timeout, and the level and status are left as they are.
- R7: The ramp holds each level 1 to 7 for exactly `STEP_CYC` reference cycles, then stays at 8. A level never rises by more than 1 per cycle.
- R8: A timeout during the ramp drops the level to 0. The next shift-clock change restarts the ramp at level 1.
- R9: `wd_stat_o` stays at 1 until a `stat_cap_i` pulse arrives while no timeout is active. A capture pulse during a timeout leaves it at 1.
- R10: `out_en_o` is 1 exactly when `lvl_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial shift clock, asynchronous to `clk_i` |
| wd_dis_i | input | 1 | 1 disables the timeout |
| stat_cap_i | input | 1 | One-cycle pulse: status word captured into the shift path |
| lvl_o | output | 4 | Soft-start brightness level, 0 (off) to 8 (full) |
| out_en_o | output | 1 | LED outputs allowed on |
| wd_stat_o | output | 1 | Watchdog status, 1 = timeout seen |

## Verification
A wrong timer count appears at `lvl_o` as a cutoff that comes one cycle early or late. For this reason the gap tests sit on both sides of the exact cycle boundary. A ramp counter or level register that goes wrong shows within one `STEP_CYC` interval, as a level held for the wrong number of cycles or a restart above 1. A status register whose set or clear priority is wrong shows on the first capture pulse that lands inside or after a timeout.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int unsigned RAMP_STEPS = 8;
  localparam int unsigned LVL_W      = $clog2(RAMP_STEPS + 1);
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_FULL = lvl_t'(RAMP_STEPS);
endpackage

// File: rtl/swd_edge_sync.sv
module swd_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic edge_o
);
  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], sclk_i};
  end

  // any level change of the synchronized clock is activity
  assign edge_o = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/swd_timer.sv
module swd_timer #(
  parameter int unsigned TIMEOUT_CYC = 40000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic dis_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (dis_i || edge_i)   cnt_q <= '0;
    else if (cnt_q != CNT_MAX)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign expired_o = (cnt_q == CNT_MAX) && !dis_i && !edge_i;

  AST_EXPIRE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !edge_i && !dis_i) |=> (edge_i || dis_i || expired_o)); // R4
endmodule

// File: rtl/swd_ramp.sv
module swd_ramp
  import swd_pkg::*;
#(
  parameter int unsigned STEP_CYC = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic expired_i,
  output lvl_t lvl_o
);
  localparam int unsigned SC_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(STEP_CYC - 1);

  lvl_t            lvl_q;
  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      sc_q  <= '0;
    end else if (expired_i) begin
      lvl_q <= '0;
      sc_q  <= '0;
    end else if (lvl_q == '0) begin
      sc_q <= '0;
      if (edge_i) lvl_q <= lvl_t'(1);
    end else if (lvl_q != LVL_FULL) begin
      if (sc_q == SC_LAST) begin
        sc_q  <= '0;
        lvl_q <= lvl_q + lvl_t'(1);
      end else begin
        sc_q <= sc_q + SC_W'(1);
      end
    end
  end

  assign lvl_o = lvl_q;

  AST_RAMP_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|lvl_q) |-> (lvl_q == lvl_t'(1))); // R8
  AST_RAMP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != '0) |=> (lvl_q == '0 || (lvl_q >= $past(lvl_q) && lvl_q <= $past(lvl_q) + 1))); // R7
  AST_RAMP_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q == LVL_FULL && !expired_i) |=> (lvl_q == LVL_FULL)); // R7
endmodule

// File: rtl/sclk_wdog.sv
module sclk_wdog
  import swd_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 40000,
  parameter int unsigned STEP_CYC    = 4096,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             wd_dis_i,
  input  logic             stat_cap_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             out_en_o,
  output logic             wd_stat_o
);
  logic edge_w, expired_w, stat_q;
  lvl_t lvl_w;

  swd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .edge_o(edge_w)
  );

  swd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(edge_w), .dis_i(wd_dis_i),
    .expired_o(expired_w)
  );

  swd_ramp #(.STEP_CYC(STEP_CYC)) u_ramp (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(edge_w), .expired_i(expired_w),
    .lvl_o(lvl_w)
  );

  // set wins over capture: a capture during expiry does not clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         stat_q <= 1'b0;
    else if (expired_w)  stat_q <= 1'b1;
    else if (stat_cap_i) stat_q <= 1'b0;
  end

  assign lvl_o     = lvl_w;
  assign out_en_o  = (lvl_w != '0);
  assign wd_stat_o = stat_q;

  AST_EXPIRE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_w |=> (lvl_o == '0 && wd_stat_o)); // R5
  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_stat_o && !stat_cap_i) |=> wd_stat_o); // R9
  AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_dis_i && !wd_stat_o) |=> !wd_stat_o); // R6
  AST_EN_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_en_o) |-> $past(expired_w)); // R10
endmodule

// File: tb/sim_sclk_wdog.sv
`timescale 1ns/100ps
module sim_sclk_wdog;
  localparam int T  = 200;
  localparam int ST = 16;
  localparam int N  = 5;
  localparam int GAP   [N] = '{50, T+3, T+4, 400, 600};
  localparam int DIS   [N] = '{0, 0, 0, 1, 0};
  localparam int EXP_EN[N] = '{1, 1, 0, 1, 0};
  localparam int EXP_ST[N] = '{0, 0, 1, 0, 1};

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, dis = 1'b0, cap = 1'b0;
  logic [3:0] lvl;
  logic en, stat;
  int runs = 0, fails = 0;

  always #2.5 clk = ~clk;

  sclk_wdog #(.TIMEOUT_CYC(T), .STEP_CYC(ST)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .wd_dis_i(dis),
    .stat_cap_i(cap), .lvl_o(lvl), .out_en_o(en), .wd_stat_o(stat)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tog();
    sclk = ~sclk;
  endtask

  task automatic pulse_cap();
    cap = 1'b1; step(1); cap = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    step(2);
    chk("R1 lvl", lvl, 0); chk("R1 en", en, 0); chk("R1 stat", stat, 0);
    rst_n = 1'b1;
    step(100);
    chk("R2 lvl", lvl, 0); chk("R10 en", en, 0);
    tog(); step(2);
    chk("R3 lvl before", lvl, 0);
    step(1);
    chk("R3 lvl", lvl, 1); chk("R10 en", en, 1);
    step(ST - 1); chk("R7 hold", lvl, 1);
    step(1);      chk("R7 lvl2", lvl, 2);
    step(6 * ST); chk("R7 full", lvl, 8);
    step(20);     chk("R7 stays", lvl, 8);

    for (int i = 0; i < N; i++) begin
      dis = DIS[i][0];
      tog(); step(GAP[i]);
      chk($sformatf("R4/R6 en gap %0d", GAP[i]), en, EXP_EN[i]);
      chk($sformatf("R5/R6 stat gap %0d", GAP[i]), stat, EXP_ST[i]);
      dis = 1'b0;
      tog(); step(3 + 7 * ST + 2);
      pulse_cap();
      chk("R9 restore", stat, 0);
    end

    // sticky status across resume
    tog(); step(T + 10);
    chk("R5 stat", stat, 1); chk("R4 lvl", lvl, 0);
    tog(); step(3);
    chk("R9 held", stat, 1); chk("R8 restart", lvl, 1);
    pulse_cap();
    chk("R9 cleared", stat, 0);
    step(T + 10);
    chk("R5 again", stat, 1);
    pulse_cap();
    chk("R9 cap in expiry", stat, 1);

    // timeout mid-ramp
    tog(); step(3 + ST);
    chk("R8 mid", lvl, 2);
    step(T + 4 - 3 - ST);
    chk("R8 abort", lvl, 0); chk("R10 en off", en, 0);
    tog(); step(3);
    chk("R8 restart at 1", lvl, 1);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule